// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the software-visible settings of a four-channel DMA controller. Each channel has a source address, a destination address, a 24-bit transfer count and a 32-bit control word. One global operation word sits beside them. A plain register port reads and writes these words. Only the low 12 bits of the bus address take part in the decode.

From the stored words the block derives three things: a per-channel "active" qualifier, a global enable, and one level interrupt per channel. A separate transfer engine, which is outside this block, writes back the progress of a channel. It supplies new addresses and a new count, and it can mark the transfer as ended. The block does not move data and does not arbitrate requests.

Each channel's interrupt is a two-state machine. In IRQ_IDLE the RAISE transition goes to IRQ_PEND. It is taken when the engine marks the transfer as ended while the channel's interrupt enable is set. In IRQ_PEND the WITHDRAW transition goes back to IRQ_IDLE. It is taken only when a bus write to the control word leaves interrupt enable and transfer end not both set. All other cycles keep the state.

Top module: `dma_regfile`

## Requirements
- R1: After reset, every register reads zero and `ch_active`, `glob_en` and `irq` are all zero.
- R2: Register layout, byte offsets taken from `bus_addr[11:0]` only. Channel n starts at n*16 and holds the source at +0x0, the destination at +0x4, the count at +0xC-4 (that is +0x8) and the control word at +0xC. The operation word is at 0x040. Every stored bit, including the request source field in control bits 11:8, reads back as last written or updated. An unaligned or unmapped offset reads zero, and a write to it changes nothing.
- R3: The count keeps bits 23:0 of a write. Bits 31:24 always read zero.
- R4: Control bit 0 is enable and bit 1 is transfer end. `ch_active[n]` is 1 exactly when control bits 1:0 of channel n equal 2'b01.
- R5: `glob_en` is 1 exactly when bits 2:0 of the operation word equal 3'b001.
- R6: A cycle with `eng_valid` high loads `eng_src`, `eng_dst` and `eng_cnt` into channel `eng_ch` at the clock edge. If `eng_done` is also high, control bit 1 (transfer end) is set and the other control bits are kept.
- R7: Control bit 2 is interrupt enable. If a write-back with `eng_done` reaches a channel whose interrupt enable is set, that channel's `irq` is high from the next cycle on.
- R8: A pending `irq` falls only on a bus write to that channel's control word whose new bits 2:1 are not both 1. A control write that keeps both bits set leaves the interrupt pending. A bus write that sets both bits does not raise the interrupt.
- R9: When a bus write and an engine write-back hit the same register of the same channel in the same cycle, the bus value is stored. A bus write to a control word cancels that cycle's transfer-end set and interrupt raise for that channel. Registers the bus does not write still take the engine values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address; only bits 11:0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_valid | input | 1 | Engine write-back strobe |
| eng_ch | input | 2 | Channel of the write-back |
| eng_src | input | 32 | New source address |
| eng_dst | input | 32 | New destination address |
| eng_cnt | input | 24 | New transfer count |
| eng_done | input | 1 | Set transfer end with this write-back |
| ch_active | output | 4 | Per-channel active qualifier |
| glob_en | output | 1 | Global controller enable |
| irq | output | 4 | Per-channel level interrupt |

## Verification
The hardest case to reach is a collision on one channel: a bus write to the control word arrives in the same cycle as an engine write-back carrying `eng_done`, and the interrupt enable is set. In that case the bus must win and the raise must be dropped. The bench reaches it with one task that drives the bus write and the write-back at the same falling edge. It then repeats the collision with the bus writing a different channel's control word, where the raise must still happen. The withdrawal rules are reached by first raising an interrupt through the engine and then writing control values that keep both bits set, clear transfer end, or clear interrupt enable.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
    // word slots within a channel's 16-byte group (address bits 3:2)
    localparam int REG_SRC = 0;
    localparam int REG_DST = 1;
    localparam int REG_CNT = 2;
    localparam int REG_CTL = 3;
    // control word bit positions
    localparam int CTL_EN = 0;
    localparam int CTL_TE = 1;
    localparam int CTL_IE = 2;
    // decoded offset width and operation word offset
    localparam int DEC_W = 12;
    localparam logic [DEC_W-1:0] OP_OFS = 12'h040;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_t;
endpackage

// File: rtl/dmareg_dec.sv
module dmareg_dec
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              is_chan,
    output logic [CH_W-1:0]   hit_ch,
    output logic [1:0]        hit_reg,
    output logic              is_op
);
    localparam int SLOT_W = DEC_W - 4;

    logic [DEC_W-1:0]  off;
    logic [SLOT_W-1:0] slot;
    logic              unused_addr_hi;

    assign off            = bus_addr[DEC_W-1:0];
    assign unused_addr_hi = ^bus_addr[ADDR_W-1:DEC_W];
    assign slot           = off[DEC_W-1:4];

    always_comb begin
        is_chan = (off[1:0] == 2'b00) && (int'(slot) < NUM_CH);
        hit_ch  = slot[CH_W-1:0];
        hit_reg = off[3:2];
        is_op   = (off == OP_OFS);
    end
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              eng_we,
    input  logic [DATA_W-1:0] eng_src,
    input  logic [DATA_W-1:0] eng_dst,
    input  logic [CNT_W-1:0]  eng_cnt,
    input  logic              eng_done,
    output logic [DATA_W-1:0] src_q,
    output logic [DATA_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [DATA_W-1:0] ctl_q,
    output logic              active,
    output logic              irq
);
    irq_state_t state_q, state_d;
    logic       raise, withdraw, both_new;

    // address and count registers: bus write takes priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else begin
            if (bus_we[REG_SRC])      src_q <= bus_wdata;
            else if (eng_we)          src_q <= eng_src;
            if (bus_we[REG_DST])      dst_q <= bus_wdata;
            else if (eng_we)          dst_q <= eng_dst;
            if (bus_we[REG_CNT])      cnt_q <= bus_wdata[CNT_W-1:0];
            else if (eng_we)          cnt_q <= eng_cnt;
        end
    end

    // control word: engine only sets transfer end
    always_ff @(posedge clk) begin
        if (!rst_n)                    ctl_q <= '0;
        else if (bus_we[REG_CTL])      ctl_q <= bus_wdata;
        else if (eng_we && eng_done)   ctl_q[CTL_TE] <= 1'b1;
    end

    assign active = ctl_q[CTL_EN] && !ctl_q[CTL_TE];

    always_comb begin
        both_new = bus_wdata[CTL_IE] && bus_wdata[CTL_TE];
        raise    = eng_we && eng_done && ctl_q[CTL_IE] && !bus_we[REG_CTL];
        withdraw = bus_we[REG_CTL] && !both_new;
    end

    // interrupt state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // next state: RAISE and WITHDRAW transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (raise)    state_d = IRQ_PEND;
            IRQ_PEND: if (withdraw) state_d = IRQ_IDLE;
            default:                state_d = IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq = (state_q == IRQ_PEND);
    end
endmodule

// File: rtl/dmareg_rdmux.sv
module dmareg_rdmux
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic                           is_chan,
    input  logic [CH_W-1:0]                hit_ch,
    input  logic [1:0]                     hit_reg,
    input  logic                           is_op,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  src_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  dst_all,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ctl_all,
    input  logic [DATA_W-1:0]              op_q,
    output logic [DATA_W-1:0]              rdata
);
    always_comb begin
        rdata = '0;
        if (is_chan) begin
            unique case (hit_reg)
                2'(REG_SRC): rdata = src_all[hit_ch];
                2'(REG_DST): rdata = dst_all[hit_ch];
                2'(REG_CNT): rdata = DATA_W'(cnt_all[hit_ch]);
                2'(REG_CTL): rdata = ctl_all[hit_ch];
                default:     rdata = '0;
            endcase
        end else if (is_op) begin
            rdata = op_q;
        end
    end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_valid,
    input  logic [CH_W-1:0]   eng_ch,
    input  logic [DATA_W-1:0] eng_src,
    input  logic [DATA_W-1:0] eng_dst,
    input  logic [CNT_W-1:0]  eng_cnt,
    input  logic              eng_done,
    output logic [NUM_CH-1:0] ch_active,
    output logic              glob_en,
    output logic [NUM_CH-1:0] irq
);
    logic                          is_chan, is_op, bus_write;
    logic [CH_W-1:0]               hit_ch;
    logic [1:0]                    hit_reg;
    logic [DATA_W-1:0]             op_q;
    logic [NUM_CH-1:0][DATA_W-1:0] src_all, dst_all, ctl_all;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all;

    assign bus_write = bus_sel && bus_wr;

    dmareg_dec #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .is_chan  (is_chan),
        .hit_ch   (hit_ch),
        .hit_reg  (hit_reg),
        .is_op    (is_op)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                  op_q <= '0;
        else if (bus_write && is_op) op_q <= bus_wdata;
    end

    assign glob_en = (op_q[2:0] == 3'b001);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [3:0] we;
        logic       ch_hit;
        assign ch_hit = bus_write && is_chan && (hit_ch == CH_W'(c));
        for (genvar r = 0; r < 4; r++) begin : g_we
            assign we[r] = ch_hit && (hit_reg == 2'(r));
        end

        dmareg_chan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_we    (we),
            .bus_wdata (bus_wdata),
            .eng_we    (eng_valid && (eng_ch == CH_W'(c))),
            .eng_src   (eng_src),
            .eng_dst   (eng_dst),
            .eng_cnt   (eng_cnt),
            .eng_done  (eng_done),
            .src_q     (src_all[c]),
            .dst_q     (dst_all[c]),
            .cnt_q     (cnt_all[c]),
            .ctl_q     (ctl_all[c]),
            .active    (ch_active[c]),
            .irq       (irq[c])
        );
    end

    dmareg_rdmux #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
        .is_chan (is_chan),
        .hit_ch  (hit_ch),
        .hit_reg (hit_reg),
        .is_op   (is_op),
        .src_all (src_all),
        .dst_all (dst_all),
        .cnt_all (cnt_all),
        .ctl_all (ctl_all),
        .op_q    (op_q),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_sel,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic                          eng_valid,
    input logic [CH_W-1:0]               eng_ch,
    input logic                          eng_done,
    input logic [NUM_CH-1:0]             ch_active,
    input logic [NUM_CH-1:0]             irq,
    input logic [NUM_CH-1:0][DATA_W-1:0] ctl_all
);
    logic [11:0]       off;
    logic              unused_misc;
    logic              cnt_rd;
    logic [NUM_CH-1:0] ctl_wr;

    assign off         = bus_addr[11:0];
    assign unused_misc = ^{bus_addr[ADDR_W-1:12], bus_rdata[CNT_W-1:0]};
    assign cnt_rd      = (off[1:0] == 2'b00) && (off[3:2] == 2'd2) && (int'(off[11:4]) < NUM_CH);

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            ctl_wr[c] = bus_sel && bus_wr && (off[1:0] == 2'b00) && (off[3:2] == 2'd3)
                        && (int'(off[11:4]) == c);
        end
    end

    // R3
    cnt_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd |-> (bus_rdata[DATA_W-1:CNT_W] == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_prop
        // R7
        irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (eng_valid && (eng_ch == CH_W'(c)) && eng_done && ctl_all[c][2] && !ctl_wr[c])
            |=> irq[c]);
        // R8
        irq_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[c]) |-> $past(ctl_wr[c] && !(bus_wdata[2] && bus_wdata[1])));
        // R8
        irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[c] && !ctl_wr[c]) |=> irq[c]);
        // R4
        irq_not_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> !ch_active[c]);
        // R9
        bus_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr[c] && eng_valid && (eng_ch == CH_W'(c))) |=> (ctl_all[c] == $past(bus_wdata)));
    end
endmodule

bind dma_regfile dmareg_chk #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_dma_regfile.sv
`timescale 1ns/1ps
module test_dma_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic        eng_valid = 1'b0, eng_done = 1'b0;
    logic [1:0]  eng_ch = '0;
    logic [31:0] eng_src = '0, eng_dst = '0;
    logic [23:0] eng_cnt = '0;
    logic [3:0]  ch_active, irq;
    logic        glob_en;

    int total = 0, fails = 0, cyc = 0;
    bit done_flag = 0;

    // reference state
    logic [31:0] m_src [4];
    logic [31:0] m_dst [4];
    logic [31:0] m_cnt [4];
    logic [31:0] m_ctl [4];
    logic [31:0] m_op;
    logic [3:0]  m_irq;

    always #2 clk = ~clk;

    dma_regfile i_dma_regfile (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_valid(eng_valid), .eng_ch(eng_ch), .eng_src(eng_src),
        .eng_dst(eng_dst), .eng_cnt(eng_cnt), .eng_done(eng_done),
        .ch_active(ch_active), .glob_en(glob_en), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [31:0] a);
        logic [11:0] o;
        o = a[11:0];
        if (o[1:0] == 2'b00 && o[11:4] < 8'd4) begin
            case (o[3:2])
                2'd0: return m_src[o[5:4]];
                2'd1: return m_dst[o[5:4]];
                2'd2: return m_cnt[o[5:4]];
                default: return m_ctl[o[5:4]];
            endcase
        end
        if (o == 12'h040) return m_op;
        return 32'h0;
    endfunction

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_src[c] = 0; m_dst[c] = 0; m_cnt[c] = 0; m_ctl[c] = 0;
            end
            m_op = 0; m_irq = 0;
        end else begin
            logic [11:0] o;
            logic        bw, cw;
            int          bc;
            logic [31:0] old_ctl [4];
            o  = bus_addr[11:0];
            bw = bus_sel && bus_wr && o[1:0] == 2'b00 && o[11:4] < 8'd4;
            bc = int'(o[5:4]);
            cw = bw && o[3:2] == 2'd3;
            for (int c = 0; c < 4; c++) old_ctl[c] = m_ctl[c];
            if (eng_valid) begin
                m_src[eng_ch] = eng_src;
                m_dst[eng_ch] = eng_dst;
                m_cnt[eng_ch] = {8'h0, eng_cnt};
                if (eng_done && !(cw && bc == int'(eng_ch))) begin
                    if (old_ctl[eng_ch][2]) m_irq[eng_ch] = 1'b1;
                    m_ctl[eng_ch][1] = 1'b1;
                end
            end
            if (bw) begin
                case (o[3:2])
                    2'd0: m_src[bc] = bus_wdata;
                    2'd1: m_dst[bc] = bus_wdata;
                    2'd2: m_cnt[bc] = {8'h0, bus_wdata[23:0]};
                    default: begin
                        m_ctl[bc] = bus_wdata;
                        if (old_ctl[bc][2] && old_ctl[bc][1] && !(bus_wdata[2] && bus_wdata[1]))
                            m_irq[bc] = 1'b0;
                    end
                endcase
            end
            if (bus_sel && bus_wr && o == 12'h040) m_op = bus_wdata;
        end
    end

    // compare outputs on every clock, away from the rising edge
    always @(negedge clk) begin
        if (!done_flag) begin
            logic [3:0] exp_act;
            for (int c = 0; c < 4; c++) exp_act[c] = (m_ctl[c][1:0] == 2'b01);
            check("R4 ch_active", {28'h0, ch_active}, {28'h0, exp_act});
            check("R5 glob_en", {31'h0, glob_en}, {31'h0, m_op[2:0] == 3'b001});
            check("R7 irq", {28'h0, irq}, {28'h0, m_irq});
        end
    end

    task automatic finish_run;
        done_flag = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done_flag) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 check(tag, bus_rdata, model_read(a));
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rd_exp(input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 check(tag, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic eng(input int c, input logic [31:0] s, input logic [31:0] d,
                       input logic [23:0] n, input logic dn);
        @(negedge clk);
        eng_valid = 1; eng_ch = 2'(c); eng_src = s; eng_dst = d; eng_cnt = n; eng_done = dn;
        @(negedge clk);
        eng_valid = 0; eng_done = 0;
    endtask

    // bus write and engine write-back in one cycle
    task automatic collide(input logic [31:0] a, input logic [31:0] wd, input int c,
                           input logic [31:0] s, input logic [31:0] d, input logic dn);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = wd;
        eng_valid = 1; eng_ch = 2'(c); eng_src = s; eng_dst = d; eng_cnt = 24'h00ABCD; eng_done = dn;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; eng_valid = 0; eng_done = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        for (int a = 0; a < 16; a++) rd_exp(32'(a * 4), 32'h0, "R1 reset reg");
        rd_exp(32'h040, 32'h0, "R1 reset op");
        check("R1 irq", {28'h0, irq}, 32'h0);
        check("R1 glob_en", {31'h0, glob_en}, 32'h0);

        // R2: layout and readback
        for (int c = 0; c < 4; c++) begin
            wr(32'(c * 16 + 0), 32'h1000_0000 + 32'(c * 32'h111));
            wr(32'(c * 16 + 4), 32'h2000_0000 + 32'(c * 32'h222));
            wr(32'(c * 16 + 8), 32'h0000_3000 + 32'(c));
            wr(32'(c * 16 + 12), 32'h0000_0C00 | 32'(c << 4));
        end
        for (int a = 0; a < 16; a++) rd(32'(a * 4), "R2 readback");
        rd_exp(32'h008, 32'h0000_3000, "R2 ch0 count");
        rd_exp(32'h03C, 32'h0000_0C30, "R2 ch3 control source field");
        wr(32'hABC0_1014, 32'hDEAD_BEEF);
        rd_exp(32'h014, 32'hDEAD_BEEF, "R2 upper address ignored");
        rd_exp(32'h7770_0014, 32'hDEAD_BEEF, "R2 alias read");
        wr(32'h044, 32'hFFFF_FFFF);
        rd_exp(32'h044, 32'h0, "R2 unmapped read");
        rd_exp(32'h040, 32'h0, "R2 unmapped write no effect");
        wr(32'h001, 32'h5555_5555);
        rd_exp(32'h000, 32'h1000_0000, "R2 unaligned write no effect");

        // R3: count width
        wr(32'h028, 32'hFFFF_FFFF);
        rd_exp(32'h028, 32'h00FF_FFFF, "R3 count upper zero");

        // R4: active qualifier
        wr(32'h00C, 32'h1);
        check("R4 active set", {31'h0, ch_active[0]}, 32'h1);
        wr(32'h00C, 32'h3);
        check("R4 active with te", {31'h0, ch_active[0]}, 32'h0);

        // R5: global enable
        wr(32'h040, 32'h1);
        check("R5 op 001", {31'h0, glob_en}, 32'h1);
        wr(32'h040, 32'h9);
        check("R5 op 1001", {31'h0, glob_en}, 32'h1);
        wr(32'h040, 32'h3);
        check("R5 op 011", {31'h0, glob_en}, 32'h0);
        wr(32'h040, 32'h5);
        check("R5 op 101", {31'h0, glob_en}, 32'h0);

        // R6, R7: engine write-back and interrupt raise
        wr(32'h01C, 32'h5);
        eng(1, 32'hA000_0040, 32'hB000_0080, 24'h000010, 1'b0);
        check("R6 no done keeps irq low", {31'h0, irq[1]}, 32'h0);
        rd_exp(32'h010, 32'hA000_0040, "R6 src writeback");
        rd_exp(32'h014, 32'hB000_0080, "R6 dst writeback");
        rd_exp(32'h018, 32'h0000_0010, "R6 cnt writeback");
        rd_exp(32'h01C, 32'h5, "R6 ctl unchanged without done");
        eng(1, 32'hA000_0060, 32'hB000_00A0, 24'h0, 1'b1);
        check("R7 irq raised", {31'h0, irq[1]}, 32'h1);
        rd_exp(32'h01C, 32'h7, "R6 te set");
        wr(32'h02C, 32'h1);
        eng(2, 32'h1, 32'h2, 24'h3, 1'b1);
        check("R7 no raise without ie", {31'h0, irq[2]}, 32'h0);
        rd_exp(32'h02C, 32'h3, "R6 te set ch2");

        // R8: withdrawal rules
        wr(32'h01C, 32'h7);
        check("R8 both kept holds irq", {31'h0, irq[1]}, 32'h1);
        wr(32'h01C, 32'h105);
        check("R8 te cleared drops irq", {31'h0, irq[1]}, 32'h0);
        wr(32'h02C, 32'h7);
        check("R8 bus set does not raise", {31'h0, irq[2]}, 32'h0);
        wr(32'h00C, 32'h5);
        eng(0, 32'h0, 32'h0, 24'h0, 1'b1);
        check("R7 ch0 raised", {31'h0, irq[0]}, 32'h1);
        wr(32'h00C, 32'h3);
        check("R8 ie cleared drops irq", {31'h0, irq[0]}, 32'h0);
        wr(32'h01C, 32'h7);
        check("R8 no raise after clear", {31'h0, irq[1]}, 32'h0);

        // R9: collisions
        wr(32'h03C, 32'h5);
        collide(32'h03C, 32'h4, 3, 32'hC0, 32'hD0, 1'b1);
        rd_exp(32'h03C, 32'h4, "R9 bus ctl wins");
        check("R9 raise cancelled", {31'h0, irq[3]}, 32'h0);
        rd_exp(32'h030, 32'hC0, "R9 other regs take engine");
        collide(32'h030, 32'h1234_5678, 3, 32'hEE, 32'hFF, 1'b0);
        rd_exp(32'h030, 32'h1234_5678, "R9 bus src wins");
        rd_exp(32'h034, 32'hFF, "R9 engine dst kept");
        collide(32'h00C, 32'h0, 3, 32'h1, 32'h2, 1'b1);
        check("R9 other channel raises", {31'h0, irq[3]}, 32'h1);
        rd_exp(32'h03C, 32'h6, "R9 te set other channel write");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule